// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

This block is a fully synchronous single-port memory of 18-bit words. Each word holds two 9-bit bytes. A byte is 8 data bits plus a parity bit, and the block stores the parity bit like any other bit. A read returns its word two active clock edges after the command. A write takes its data two active edges after the command. Both operations therefore use one two-stage pipeline, and reads and writes can follow each other on every cycle with no idle cycle on the data path. Write data is first captured in a one-entry write buffer and is stored in the array on the next active edge. A read that reaches the buffer's address while the write is still pending gets the buffered bytes merged into the word it reads.

A command is either a load or an advance. A load takes a new address from the pins and runs only when the three chip selects are in their active state. An advance steps a 4-beat burst counter on the two low address bits, and the burst keeps the operation type of the load that started it. The burst order is linear or interleaved. A clock enable freezes every register. An asynchronous output enable blanks the data output without stopping the pipeline.

The burst sequencer is a three-state machine. `BST_IDLE` means no burst is open. `BST_READ` means a read burst is open and `BST_WRITE` means a write burst is open. A selected load moves the machine to `BST_READ` (read) or `BST_WRITE` (write) from any state. A deselected load returns it to `BST_IDLE`. An advance leaves the state unchanged. State and counters change only on edges where the clock enable is high.

Top module: `lw_sram`

## Requirements
- R1: Read and write commands may be issued on consecutive cycles in any order, and every read returns its data with no idle cycle inserted.
- R2: A read issued at an active edge drives `rvalid` high with its word on `rdata` after the second active edge that follows. Cycles that carry no read result show `rvalid` low and `rdata` zero.
- R3: A write's data is taken from `wdata` at the second active edge after its command, and only that value is stored.
- R4: A read of an address whose write has been captured but not yet stored returns the newest bytes of that write, merged per byte with the stored word.
- R5: `byte_we_n[0]` low enables bits [8:0] and `byte_we_n[1]` low enables bits [17:9]. A disabled byte keeps its old contents. The mask is sampled with the command.
- R6: While `cke` is low no command is issued, and the pipeline, write buffer, burst state and outputs all hold their values.
- R7: A load (`adv_ld` low) runs only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. Otherwise it issues nothing, closes any open burst, and its output slot two edges later is idle.
- R8: An advance (`adv_ld` high) issues the next beat of the open burst with that burst's read/write type, whatever the chip selects and `rd_wrn` show. With no open burst an advance does nothing.
- R9: Beat n (0..3, wrapping) of a burst that starts at low bits s uses low address bits (s+n) mod 4 when `order_lin`=1, and s XOR n when `order_lin`=0. The upper address bits stay fixed.
- R10: `oe_n` high forces `rdata` to zero at once. `rvalid` and the pipeline are not affected.
- R11: After reset `rvalid` and `rdata` are zero, no write is pending, and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| cke | input | 1 | Clock enable; low freezes the block |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| rd_wrn | input | 1 | 1 = read, 0 = write, sampled on a load |
| byte_we_n | input | 2 | Per-byte write enables, active low |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| order_lin | input | 1 | 1 = linear burst order, 0 = interleaved |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 18 | Write data, sampled two active edges after its command |
| rdata | output | 18 | Read data |
| rvalid | output | 1 | Read data valid |

## Verification
The hardest case to reach is a read that lands on a write still held in the buffer. It needs a write followed by a read of the same address on the very next cycle, and it must also hold when clock-enable stalls fall between the two or between the write command and its data. The bench makes this happen on purpose with partial byte masks, then reaches it at random by mixing reads, writes, bursts and stalls over a small address space. Every result is compared against a reference model that applies writes in command order.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
    localparam int BYTE_W = 9;
    localparam int NBYTES = 2;
    localparam int WORD_W = BYTE_W * NBYTES;

    typedef enum logic [1:0] {
        BST_IDLE  = 2'd0,
        BST_READ  = 2'd1,
        BST_WRITE = 2'd2
    } bst_state_e;

    // low address bits of beat n for a burst starting at s
    function automatic logic [1:0] beat_lo(input logic [1:0] s, input logic [1:0] n,
                                           input logic lin);
        return lin ? (s + n) : (s ^ n);
    endfunction
endpackage

// File: rtl/lw_sram_burst.sv
module lw_sram_burst
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              sel,
    input  logic              rd_wrn,
    input  logic              adv_ld,
    input  logic              order_lin,
    input  logic [ADDR_W-1:0] addr,
    output logic              iss_vld,
    output logic              iss_wr,
    output logic [ADDR_W-1:0] iss_addr
);
    bst_state_e        state_q, state_d;
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nx;

    assign cnt_nx = cnt_q + 2'd1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BST_IDLE;
        end else if (cke) begin
            state_q <= state_d;
        end
    end

    // burst origin and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (cke) begin
            if (!adv_ld && sel) begin
                base_q <= addr;
                cnt_q  <= '0;
            end else if (adv_ld && state_q != BST_IDLE) begin
                cnt_q  <= cnt_nx;
            end
        end
    end

    // next state and issued command
    always_comb begin
        state_d  = state_q;
        iss_vld  = 1'b0;
        iss_wr   = 1'b0;
        iss_addr = addr;
        if (!adv_ld) begin
            if (!sel)        state_d = BST_IDLE;
            else if (rd_wrn) state_d = BST_READ;
            else             state_d = BST_WRITE;
            iss_vld = sel;
            iss_wr  = sel && !rd_wrn;
        end else begin
            iss_addr = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_nx, order_lin)};
            unique case (state_q)
                BST_READ: begin
                    iss_vld = 1'b1;
                end
                BST_WRITE: begin
                    iss_vld = 1'b1;
                    iss_wr  = 1'b1;
                end
                default: begin
                    iss_vld = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              cke,
    input  logic              wb_vld,
    input  logic [ADDR_W-1:0] wb_addr,
    input  logic [NBYTES-1:0] wb_be,
    input  logic [WORD_W-1:0] wb_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic hit;
    assign hit = wb_vld && (wb_addr == rd_addr);

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        logic [BYTE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (cke && wb_vld && wb_be[b]) begin
                mem[wb_addr] <= wb_data[b*BYTE_W +: BYTE_W];
            end
        end

        // pending-write forwarding, merged per byte
        assign rd_word[b*BYTE_W +: BYTE_W] = (hit && wb_be[b]) ?
                                             wb_data[b*BYTE_W +: BYTE_W] : mem[rd_addr];
    end
endmodule

// File: rtl/lw_sram_pipe.sv
module lw_sram_pipe
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              iss_vld,
    input  logic              iss_wr,
    input  logic [ADDR_W-1:0] iss_addr,
    input  logic [NBYTES-1:0] iss_be,
    input  logic [WORD_W-1:0] wdata,
    input  logic [WORD_W-1:0] rd_word,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wb_vld,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [NBYTES-1:0] wb_be,
    output logic [WORD_W-1:0] wb_data,
    output logic [WORD_W-1:0] dq,
    output logic              dq_vld
);
    logic              s1_vld, s1_wr, s2_vld, s2_wr;
    logic [ADDR_W-1:0] s1_addr, s2_addr;
    logic [NBYTES-1:0] s1_be, s2_be;

    assign rd_addr = s2_addr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;  s1_wr <= 1'b0;  s1_addr <= '0;  s1_be <= '0;
            s2_vld <= 1'b0;  s2_wr <= 1'b0;  s2_addr <= '0;  s2_be <= '0;
            wb_vld <= 1'b0;  wb_addr <= '0;  wb_be <= '0;    wb_data <= '0;
            dq     <= '0;    dq_vld <= 1'b0;
        end else if (cke) begin
            s1_vld  <= iss_vld;
            s1_wr   <= iss_wr;
            s1_addr <= iss_addr;
            s1_be   <= iss_be;
            s2_vld  <= s1_vld;
            s2_wr   <= s1_wr;
            s2_addr <= s1_addr;
            s2_be   <= s1_be;
            dq_vld  <= s2_vld && !s2_wr;
            dq      <= (s2_vld && !s2_wr) ? rd_word : '0;
            wb_vld  <= s2_vld && s2_wr;
            if (s2_vld && s2_wr) begin
                wb_addr <= s2_addr;
                wb_be   <= s2_be;
                wb_data <= wdata;
            end
        end
    end
endmodule

// File: rtl/lw_sram.sv
module lw_sram
    import lw_sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cke,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              rd_wrn,
    input  logic [1:0]        byte_we_n,
    input  logic              adv_ld,
    input  logic              order_lin,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [17:0]       wdata,
    output logic [17:0]       rdata,
    output logic              rvalid
);
    logic              sel;
    logic              iss_vld, iss_wr;
    logic [ADDR_W-1:0] iss_addr, rd_addr, wb_addr;
    logic              wb_vld;
    logic [NBYTES-1:0] wb_be;
    logic [WORD_W-1:0] wb_data, rd_word, dq;

    assign sel = !sel0_n && sel1 && !sel2_n;

    lw_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk(clk), .rst_n(rst_n), .cke(cke), .sel(sel), .rd_wrn(rd_wrn),
        .adv_ld(adv_ld), .order_lin(order_lin), .addr(addr),
        .iss_vld(iss_vld), .iss_wr(iss_wr), .iss_addr(iss_addr)
    );

    lw_sram_pipe #(.ADDR_W(ADDR_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .cke(cke),
        .iss_vld(iss_vld), .iss_wr(iss_wr), .iss_addr(iss_addr), .iss_be(~byte_we_n),
        .wdata(wdata), .rd_word(rd_word), .rd_addr(rd_addr),
        .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_be(wb_be), .wb_data(wb_data),
        .dq(dq), .dq_vld(rvalid)
    );

    lw_sram_array #(.ADDR_W(ADDR_W)) u_array (
        .clk(clk), .cke(cke), .wb_vld(wb_vld), .wb_addr(wb_addr), .wb_be(wb_be),
        .wb_data(wb_data), .rd_addr(rd_addr), .rd_word(rd_word)
    );

    assign rdata = oe_n ? '0 : dq;
endmodule

// File: rtl/lw_sram_chk.sv
module lw_sram_chk (
    input logic clk,
    input logic rst_n,
    input logic cke,
    input logic adv_ld,
    input logic sel0_n,
    input logic sel1,
    input logic sel2_n,
    input logic iss_vld,
    input logic iss_wr,
    input logic rvalid
);
    logic [1:0] age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          age <= '0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (age == 2'd3 && $past(cke, 3) && $past(cke, 2) && $past(cke, 1))
        |-> (rvalid == $past(iss_vld && !iss_wr, 3)));                       // R2

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && !$past(cke)) |-> $stable(rvalid));                    // R6

    AST_DESEL_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv_ld && !(!sel0_n && sel1 && !sel2_n)) |-> !iss_vld);             // R7

    AST_BURST_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
        (age != 2'd0 && cke && adv_ld && iss_vld && $past(cke && iss_vld))
        |-> (iss_wr == $past(iss_wr)));                                       // R8
endmodule

bind lw_sram lw_sram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke), .adv_ld(adv_ld),
    .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
    .iss_vld(iss_vld), .iss_wr(iss_wr), .rvalid(rvalid)
);

// File: tb/lw_sram_bench.sv
`timescale 1ns/1ps
module lw_sram_bench;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL_ON = 3'b010;   // {sel0_n, sel1, sel2_n}
    localparam logic [2:0] SEL_OFF = 3'b110;

    logic clk = 1'b0, rst_n = 1'b0, cke = 1'b0, sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic rd_wrn = 1'b1, adv_ld = 1'b0, order_lin = 1'b1, oe_n = 1'b0;
    logic [1:0] byte_we_n = 2'b11;
    logic [AW-1:0] addr = '0;
    logic [17:0] wdata = '0;
    logic [17:0] rdata;
    logic rvalid;

    always #2 clk = ~clk;

    lw_sram #(.ADDR_W(AW)) u_lw_sram (
        .clk(clk), .rst_n(rst_n), .cke(cke), .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .rd_wrn(rd_wrn), .byte_we_n(byte_we_n), .adv_ld(adv_ld), .order_lin(order_lin),
        .oe_n(oe_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
    );

    int checks = 0, errors = 0, rv_seen = 0;

    // reference model
    logic [17:0] ref_mem [DEPTH];
    logic b_act = 1'b0, b_wr = 1'b0;
    logic [AW-1:0] b_base = '0;
    logic [1:0] b_cnt = '0;
    logic p1_v = 0, p1_w = 0, p2_v = 0, p2_w = 0, p3_v = 0, p3_w = 0;
    logic [17:0] p1_d = 0, p2_d = 0, p3_d = 0;
    logic [AW-1:0] p1_a = 0, p2_a = 0, p3_a = 0;

    task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive at negedge, model the edge, check at the next negedge
    task automatic step(input logic c, input logic [2:0] cs, input logic rw, input logic adv,
                        input logic lin, input logic [1:0] ben, input logic [AW-1:0] a,
                        input logic oe, input string tag);
        logic m_v, m_w;
        logic [AW-1:0] m_a;
        logic [17:0] m_d, nd;
        logic [1:0] n;
        cke = c; {sel0_n, sel1, sel2_n} = cs; rd_wrn = rw; adv_ld = adv;
        order_lin = lin; byte_we_n = ben; addr = a; oe_n = oe;
        wdata = (p2_v && p2_w) ? p2_d : 18'($urandom);
        m_v = 1'b0; m_w = 1'b0; m_a = a; m_d = 18'($urandom);
        n = b_cnt + 2'd1;
        if (!adv) begin
            m_v = (cs == SEL_ON); m_w = (cs == SEL_ON) && !rw;
        end else if (b_act) begin
            m_v = 1'b1; m_w = b_wr;
            m_a = {b_base[AW-1:2], lin ? (b_base[1:0] + n) : (b_base[1:0] ^ n)};
        end
        if (c && m_v && m_w) begin
            nd = ref_mem[m_a];
            if (!ben[0]) nd[8:0] = m_d[8:0];
            if (!ben[1]) nd[17:9] = m_d[17:9];
            ref_mem[m_a] = nd;
        end
        if (c && m_v && !m_w) m_d = ref_mem[m_a];
        @(posedge clk);
        if (c) begin
            if (!adv) begin
                b_act = (cs == SEL_ON); b_wr = !rw;
                if (cs == SEL_ON) begin b_base = a; b_cnt = 2'd0; end
            end else if (b_act) begin
                b_cnt = n;
            end
            p3_v = p2_v; p3_w = p2_w; p3_d = p2_d; p3_a = p2_a;
            p2_v = p1_v; p2_w = p1_w; p2_d = p1_d; p2_a = p1_a;
            p1_v = m_v;  p1_w = m_w;  p1_d = m_d;  p1_a = m_a;
        end
        @(negedge clk);
        if (rvalid) rv_seen++;
        if (p3_v && !p3_w) begin
            chk(rvalid == 1'b1, tag, 32'(rvalid), 32'd1);
            chk(rdata == (oe ? 18'd0 : p3_d), tag, 32'(rdata), 32'(oe ? 18'd0 : p3_d));
        end else begin
            chk(rvalid == 1'b0 && rdata == 18'd0, tag, {13'd0, rvalid, rdata}, 32'd0);
        end
    endtask

    task automatic idle(input int k, input string tag);
        for (int i = 0; i < k; i++) step(1'b1, SEL_OFF, 1'b1, 1'b0, 1'b1, 2'b11, '0, 1'b0, tag);
    endtask

    // {cke, cs[2:0], rd_wrn, adv_ld, order_lin, byte_we_n[1:0], oe_n, addr[5:0]}
    localparam logic [15:0] VEC [16] = '{
        {1'b1, SEL_ON,  1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 6'd10},  // write 10
        {1'b1, SEL_ON,  1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 6'd10},  // read 10 at once
        {1'b1, SEL_ON,  1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 6'd10},  // write byte b only
        {1'b0, SEL_ON,  1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 6'd11},  // stalled
        {1'b1, SEL_ON,  1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 6'd10},  // read 10
        {1'b1, SEL_OFF, 1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 6'd10},  // deselected
        {1'b1, 3'b000,  1'b0, 1'b0, 1'b1, 2'b00, 1'b0, 6'd20},  // sel1 low: no write
        {1'b1, 3'b011,  1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 6'd20},  // sel2_n high: no read
        {1'b1, SEL_ON,  1'b1, 1'b0, 1'b1, 2'b11, 1'b0, 6'd20},  // read 20
        {1'b1, SEL_ON,  1'b0, 1'b0, 1'b0, 2'b10, 1'b0, 6'd33},  // write burst, byte a
        {1'b1, SEL_OFF, 1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 6'd0},   // advance ignores sel/rw
        {1'b0, SEL_ON,  1'b1, 1'b1, 1'b0, 2'b10, 1'b0, 6'd0},   // stall mid-burst
        {1'b1, SEL_ON,  1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 6'd0},   // advance
        {1'b1, SEL_ON,  1'b1, 1'b0, 1'b0, 2'b11, 1'b0, 6'd33},  // read burst 33
        {1'b1, SEL_ON,  1'b0, 1'b1, 1'b0, 2'b11, 1'b1, 6'd0},   // advance, oe high
        {1'b1, SEL_ON,  1'b0, 1'b1, 1'b0, 2'b11, 1'b0, 6'd0}    // advance
    };

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs idle in reset and after release
        chk(rvalid == 1'b0 && rdata == 18'd0, "R11", {13'd0, rvalid, rdata}, 32'd0);
        rst_n = 1'b1;
        idle(3, "R11");

        // preload all words with linear write bursts (R9)
        for (int i = 0; i < DEPTH / 4; i++) begin
            step(1'b1, SEL_ON, 1'b0, 1'b0, 1'b1, 2'b00, AW'(4 * i), 1'b0, "R9");
            for (int j = 0; j < 3; j++)
                step(1'b1, SEL_OFF, 1'b1, 1'b1, 1'b1, 2'b00, '0, 1'b0, "R9");
        end
        idle(3, "R3");
        for (int i = 0; i < DEPTH; i++) step(1'b1, SEL_ON, 1'b1, 1'b0, 1'b1, 2'b11, AW'(i), 1'b0, "R3");
        idle(3, "R3");

        // table of vectors (R4 R5 R6 R7 R8 R10)
        for (int i = 0; i < 16; i++)
            step(VEC[i][15], VEC[i][14:12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:7],
                 VEC[i][5:0], VEC[i][6], "R5");
        idle(3, "R10");

        // R4: write with one byte then read the same word on the next cycle
        step(1'b1, SEL_ON, 1'b0, 1'b0, 1'b1, 2'b10, 6'd7, 1'b0, "R4");
        step(1'b1, SEL_ON, 1'b1, 1'b0, 1'b1, 2'b11, 6'd7, 1'b0, "R4");
        step(1'b1, SEL_ON, 1'b0, 1'b0, 1'b1, 2'b01, 6'd7, 1'b0, "R4");
        step(1'b0, SEL_ON, 1'b1, 1'b0, 1'b1, 2'b11, 6'd7, 1'b0, "R4");
        step(1'b1, SEL_ON, 1'b1, 1'b0, 1'b1, 2'b11, 6'd7, 1'b0, "R4");
        idle(3, "R4");

        // R8: advance with no open burst issues nothing
        step(1'b1, SEL_ON, 1'b1, 1'b1, 1'b1, 2'b11, 6'd0, 1'b0, "R8");
        idle(3, "R8");

        // R9: interleaved read burst from low bits 01
        step(1'b1, SEL_ON, 1'b1, 1'b0, 1'b0, 2'b11, 6'd45, 1'b0, "R9");
        for (int j = 0; j < 5; j++) step(1'b1, SEL_OFF, 1'b0, 1'b1, 1'b0, 2'b00, '0, 1'b0, "R9");
        idle(3, "R9");

        // R1: alternating writes and reads, no gaps
        rv_seen = 0;
        for (int i = 0; i < 16; i++)
            step(1'b1, SEL_ON, i[0], 1'b0, 1'b1, 2'b00, AW'(i / 2 + 40), 1'b0, "R1");
        idle(3, "R1");
        chk(rv_seen == 8, "R1", 32'(rv_seen), 32'd8);

        // R6 R2: random mix with stalls and bursts
        for (int i = 0; i < 4000; i++) begin
            logic c, adv;
            logic [2:0] cs;
            c = ($urandom % 5) != 0;
            adv = ($urandom % 3) == 0;
            cs = (($urandom % 6) == 0) ? 3'($urandom) : SEL_ON;
            step(c, cs, 1'($urandom), adv, 1'($urandom), 2'($urandom), AW'($urandom % 8),
                 (($urandom % 10) == 0), "R2");
        end
        idle(3, "R6");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule